// File: doc/BRIEF.md
# Uncore Performance Counter Bank

This block is a bank of event counters for an uncore agent such as a cache slice or a home agent. The agent supplies a vector of single-cycle event pulses. Each counter holds an 8-bit event code that picks one line of that vector. On every clock where the picked line is high, the counter adds one. Counting needs two things at once: a single master enable bit, and that counter's own bit in an enable bitmap.

Software reaches the bank through a plain register port. The port has a write strobe, an address and 64-bit write data, and its read data follows the address combinationally. Counters are 48 bits wide. When a counter steps from its all-ones value to zero, it sets an overflow flag. The flag drives a level interrupt unless that counter is masked, and it stays set until software writes a 1 to clear it.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset the master enable and the enable bitmap read 0, every mask bit reads 1, every event-select lane reads 0xFF, every counter and every status bit reads 0, and `irq_o` is low.
- R2: The event code sits in event-select register n/4, byte lane n%4 (bits 8*(n%4)+7 : 8*(n%4)). A code c below NUM_EVT selects `evt_i[c]`. The counter adds exactly one on each rising edge where its selected line is high and counting is allowed.
- R3: While control bit 0 (the master enable) is 0, no counter changes value on its own.
- R4: A counter whose bit n in the enable bitmap is 0 does not count, even while the master enable is 1.
- R5: Event code 0xFF, and any code at or above NUM_EVT, selects no event, so the counter never counts.
- R6: A counter read returns its 48-bit value in bits 47:0, with bits 63:48 reading zero. A write loads bits 47:0 and discards bits 63:48. A write to a counter takes priority over an increment in the same cycle.
- R7: An increment that takes a counter from 2^48-1 to 0 sets status bit n, whatever the value of mask bit n.
- R8: `irq_o` is high exactly while some status bit is 1 and its mask bit is 0. It holds that level until a clear or a mask write removes the cause.
- R9: Writing the clear register clears each status bit whose write-data bit is 1 and leaves every bit written 0 unchanged. If a clear and a new overflow of the same counter land in the same cycle, the status bit stays 1.
- R10: Register offsets are:
  - control at 0x000
  - enable bitmap at 0x004
  - interrupt mask at 0x008
  - status at 0x00C (read only)
  - clear at 0x010 (reads zero)
  - event-select register k at 0x040+4*k
  - counter n at 0x100+8*n

  Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event pulses, one line per event code |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 64 | Write data (32-bit registers use bits 31:0) |
| rdata_o | output | 64 | Read data for `addr_i` |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench keeps 16 counters at the full 48-bit width and narrows NUM_EVT to 32. With a 32-line vector, codes from 32 to 254 fall into the unimplemented range, so R5 is exercised with a real code as well as with 0xFF. Because 32 is a power of two, the build also uses the direct-index event selector. The wrap and its race against a same-cycle clear are reached at full width by preloading counters close to 2^48-1 through the register port. The counter index the bench places in each table row touches every event-select byte lane.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;
   localparam int REG_AW = 12;
   localparam int CODE_W = 8;
   localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;
   localparam logic [REG_AW-1:0] OFS_CTRL = 12'h000;
   localparam logic [REG_AW-1:0] OFS_EN   = 12'h004;
   localparam logic [REG_AW-1:0] OFS_MASK = 12'h008;
   localparam logic [REG_AW-1:0] OFS_STAT = 12'h00C;
   localparam logic [REG_AW-1:0] OFS_CLR  = 12'h010;
   localparam logic [REG_AW-1:0] OFS_SEL  = 12'h040;
   localparam logic [REG_AW-1:0] OFS_CNT  = 12'h100;
endpackage

// File: rtl/perfbank_evt_pick.sv
module perfbank_evt_pick #(
   parameter int NUM_EVT = 64,
   parameter int CODE_W  = 8
) (
   input  logic [CODE_W-1:0]  code_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               hit_o
);
   localparam int  LW     = $clog2(NUM_EVT);
   localparam bit  IS_POW2 = (NUM_EVT & (NUM_EVT - 1)) == 0;

   generate
      if (IS_POW2) begin : g_direct
         // upper code bits must be zero, so 0xFF and out-of-range codes miss
         assign hit_o = (code_i[CODE_W-1:LW] == '0) && evt_i[code_i[LW-1:0]];
      end else begin : g_scan
         always_comb begin
            hit_o = 1'b0;
            for (int i = 0; i < NUM_EVT; i++) begin
               if (code_i == CODE_W'(i)) hit_o = evt_i[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/perfbank_ctr.sv
module perfbank_ctr #(
   parameter int CTR_W = 48
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ld_i,
   input  logic [CTR_W-1:0] ld_val_i,
   input  logic             inc_i,
   output logic [CTR_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CTR_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (ld_i)  cnt_q <= ld_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = inc_i && !ld_i && (&cnt_q);

   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (cnt_q == $past(ld_val_i)));                              // R6
   AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));              // R2
   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !ld_i) |=> $stable(cnt_q));                             // R4
endmodule

// File: rtl/perfbank_irq.sv
module perfbank_irq #(
   parameter int NUM_CTR = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CTR-1:0] wrap_i,
   input  logic               clr_we_i,
   input  logic               mask_we_i,
   input  logic [NUM_CTR-1:0] wdata_i,
   output logic [NUM_CTR-1:0] status_o,
   output logic [NUM_CTR-1:0] mask_o,
   output logic               irq_o
);
   logic [NUM_CTR-1:0] status_q, mask_q, clr_bits;

   assign clr_bits = clr_we_i ? wdata_i : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         // a same-cycle wrap re-sets the flag after the clear
         status_q <= (status_q & ~clr_bits) | wrap_i;
         if (mask_we_i) mask_q <= wdata_i;
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign irq_o    = |(status_q & ~mask_q);

   AST_WRAP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i != '0) |=> ((status_q & $past(wrap_i)) == $past(wrap_i)));   // R7
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));    // R9
   AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(clr_we_i || mask_we_i));                      // R8
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
   import perfbank_pkg::*;
#(
   parameter int NUM_CTR = 16,
   parameter int CTR_W   = 48,
   parameter int NUM_EVT = 64
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               we_i,
   input  logic [REG_AW-1:0]  addr_i,
   input  logic [63:0]        wdata_i,
   output logic [63:0]        rdata_o,
   output logic               irq_o
);
   localparam int NSEL = (NUM_CTR + 3) / 4;

   generate
      if (NUM_CTR < 2 || NUM_CTR > 32) begin : g_bad_nctr
         $error("NUM_CTR must lie in 2..32");
      end
      if (CTR_W < 2 || CTR_W > 63) begin : g_bad_width
         $error("CTR_W must lie in 2..63");
      end
      if (NUM_EVT < 2 || NUM_EVT > 255) begin : g_bad_nevt
         $error("NUM_EVT must lie in 2..255");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [REG_AW-1:0] cnt_off, sel_off;
   logic              cnt_hit, sel_hit;
   int                cnt_idx, sel_idx;

   always_comb begin
      cnt_off = addr_i - OFS_CNT;
      sel_off = addr_i - OFS_SEL;
      cnt_idx = int'(cnt_off[REG_AW-1:3]);
      sel_idx = int'(sel_off[REG_AW-1:2]);
      cnt_hit = (addr_i >= OFS_CNT) && (cnt_off[2:0] == 3'd0) && (cnt_idx < NUM_CTR);
      sel_hit = (addr_i >= OFS_SEL) && (sel_off[1:0] == 2'd0) && (sel_idx < NSEL);
   end

   // ---------------- configuration registers ----------------
   logic               ctrl_q;
   logic [NUM_CTR-1:0] en_q;
   logic [CODE_W-1:0]  code_q [NUM_CTR];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q <= 1'b0;
         en_q   <= '0;
         for (int g = 0; g < NUM_CTR; g++) code_q[g] <= CODE_NONE;
      end else if (we_i) begin
         if (addr_i == OFS_CTRL) ctrl_q <= wdata_i[0];
         if (addr_i == OFS_EN)   en_q   <= wdata_i[NUM_CTR-1:0];
         for (int g = 0; g < NUM_CTR; g++) begin
            if (sel_hit && sel_idx == g / 4) code_q[g] <= wdata_i[8*(g%4) +: 8];
         end
      end
   end

   // ---------------- counter slices ----------------
   logic [CTR_W-1:0]   cnt_w [NUM_CTR];
   logic [NUM_CTR-1:0] hit_w, inc_w, ld_w, wrap_w;

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      perfbank_evt_pick #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_pick (
         .code_i (code_q[g]),
         .evt_i  (evt_i),
         .hit_o  (hit_w[g])
      );

      assign inc_w[g] = ctrl_q && en_q[g] && hit_w[g];
      assign ld_w[g]  = we_i && cnt_hit && (cnt_idx == g);

      perfbank_ctr #(.CTR_W(CTR_W)) u_ctr (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .ld_i     (ld_w[g]),
         .ld_val_i (wdata_i[CTR_W-1:0]),
         .inc_i    (inc_w[g]),
         .cnt_o    (cnt_w[g]),
         .wrap_o   (wrap_w[g])
      );
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata_i[63:CTR_W];

   // ---------------- overflow status and interrupt ----------------
   logic [NUM_CTR-1:0] status_w, mask_w;

   perfbank_irq #(.NUM_CTR(NUM_CTR)) u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wrap_i    (wrap_w),
      .clr_we_i  (we_i && addr_i == OFS_CLR),
      .mask_we_i (we_i && addr_i == OFS_MASK),
      .wdata_i   (wdata_i[NUM_CTR-1:0]),
      .status_o  (status_w),
      .mask_o    (mask_w),
      .irq_o     (irq_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata_o = '0;
      if (addr_i == OFS_CTRL) rdata_o[0]           = ctrl_q;
      if (addr_i == OFS_EN)   rdata_o[NUM_CTR-1:0] = en_q;
      if (addr_i == OFS_MASK) rdata_o[NUM_CTR-1:0] = mask_w;
      if (addr_i == OFS_STAT) rdata_o[NUM_CTR-1:0] = status_w;
      for (int g = 0; g < NUM_CTR; g++) begin
         if (sel_hit && sel_idx == g / 4) rdata_o[8*(g%4) +: 8] = code_q[g];
         if (cnt_hit && cnt_idx == g)     rdata_o[CTR_W-1:0]    = cnt_w[g];
      end
   end

   AST_CNT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_hit |-> (rdata_o[63:CTR_W] == '0));                            // R6
   AST_MASTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q |-> (inc_w == '0));                                        // R3
endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
   localparam int NEVT = 32;
   localparam logic [11:0] A_CTRL = 12'h000, A_EN = 12'h004, A_MASK = 12'h008,
                           A_STAT = 12'h00C, A_CLR = 12'h010, A_SEL = 12'h040,
                           A_CNT = 12'h100;
   localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NEVT-1:0] evt = '0;
   logic            we = 1'b0;
   logic [11:0]     addr = '0;
   logic [63:0]     wdata = '0;
   logic [63:0]     rdata;
   logic            irq;
   int              n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   perf_counter_bank #(.NUM_CTR(16), .CTR_W(48), .NUM_EVT(NEVT)) u_perf_counter_bank (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

   // row: ctr[34:31] code[30:23] line[22:18] master[17] en[16] pulses[15:8] expect[7:0]
   localparam logic [34:0] TBL [8] = '{
      {4'd0,  8'h03, 5'd3,  1'b1, 1'b1, 8'd5, 8'd5},  // R2 selected line counts
      {4'd5,  8'h03, 5'd4,  1'b1, 1'b1, 8'd5, 8'd0},  // R2 other line ignored
      {4'd7,  8'h11, 5'd17, 1'b0, 1'b1, 8'd4, 8'd0},  // R3 master off
      {4'd9,  8'h11, 5'd17, 1'b1, 1'b0, 8'd4, 8'd0},  // R4 own enable off
      {4'd15, 8'hFF, 5'd31, 1'b1, 1'b1, 8'd6, 8'd0},  // R5 no-event code
      {4'd12, 8'h28, 5'd8,  1'b1, 1'b1, 8'd6, 8'd0},  // R5 code beyond NUM_EVT
      {4'd3,  8'h1F, 5'd31, 1'b1, 1'b1, 8'd9, 8'd9},  // R2 lane 3, top line
      {4'd14, 8'h00, 5'd0,  1'b1, 1'b1, 8'd3, 8'd3}   // R2 lane 2, line 0
   };

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rchk(input string tag, input logic [11:0] a, input logic [63:0] exp);
      logic [63:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rchk("R1 control", A_CTRL, 64'd0);
      rchk("R1 enable", A_EN, 64'd0);
      rchk("R1 mask", A_MASK, 64'h0000_0000_0000_FFFF);
      rchk("R1 select reg 0", A_SEL, 64'h0000_0000_FFFF_FFFF);
      rchk("R1 select reg 3", A_SEL + 12'd12, 64'h0000_0000_FFFF_FFFF);
      rchk("R1 counter 11", A_CNT + 12'd88, 64'd0);
      rchk("R1 status", A_STAT, 64'd0);
      chk("R1 irq", {63'd0, irq}, 64'd0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         int ctr;
         logic [31:0] selw;
         ctr = int'(TBL[i][34:31]);
         selw = 32'hFFFF_FFFF;
         selw[8*(ctr%4) +: 8] = TBL[i][30:23];
         wr(A_CNT + 12'(8*ctr), 64'd0);
         wr(A_SEL + 12'(4*(ctr/4)), {32'd0, selw});
         wr(A_EN, TBL[i][16] ? (64'd1 << ctr) : 64'd0);
         wr(A_CTRL, {63'd0, TBL[i][17]});
         for (int p = 0; p < int'(TBL[i][15:8]); p++) begin
            @(negedge clk);
            evt = NEVT'(1) << TBL[i][22:18];
         end
         @(negedge clk);
         evt = '0;
         wr(A_CTRL, 64'd0);
         rchk($sformatf("R2/R3/R4/R5 row %0d", i), A_CNT + 12'(8*ctr), {56'd0, TBL[i][7:0]});
      end

      // R6 upper bits discarded on write, read as zero
      wr(A_CNT + 12'd16, 64'hABCD_1234_5678_9ABC);
      rchk("R6 upper bits", A_CNT + 12'd16, 64'h0000_1234_5678_9ABC);

      // R10 unmapped and clear register read zero
      rchk("R10 unmapped", 12'h020, 64'd0);
      rchk("R10 clear reads zero", A_CLR, 64'd0);

      // R7 wrap with mask set: counter 4, code 2 in reg 1 lane 0
      wr(A_SEL + 12'd4, 64'h0000_0000_FFFF_FF02);
      wr(A_EN, 64'h10);
      wr(A_CNT + 12'd32, MAX48 - 64'd1);
      wr(A_CTRL, 64'd1);
      repeat (2) begin
         @(negedge clk);
         evt = 32'h4;
      end
      @(negedge clk);
      evt = '0;
      rchk("R7 counter wrapped", A_CNT + 12'd32, 64'd0);
      rchk("R7 flag while masked", A_STAT, 64'h10);
      chk("R8 irq masked", {63'd0, irq}, 64'd0);
      wr(A_MASK, 64'hFFEF);
      chk("R8 irq unmasked", {63'd0, irq}, 64'd1);
      wr(A_CLR, 64'd0);
      rchk("R9 zero clear keeps", A_STAT, 64'h10);
      chk("R8 irq held", {63'd0, irq}, 64'd1);
      wr(A_CLR, 64'h10);
      rchk("R9 clear", A_STAT, 64'd0);
      chk("R8 irq drops", {63'd0, irq}, 64'd0);

      // R6 write wins over same-cycle increment
      @(negedge clk);
      evt = 32'h4;
      wr(A_CNT + 12'd32, 64'd100);
      rchk("R6 load wins", A_CNT + 12'd32, 64'd100);
      @(negedge clk);
      rchk("R2 count after load", A_CNT + 12'd32, 64'd101);
      evt = '0;

      // R9 clear and wrap in the same cycle
      wr(A_CNT + 12'd32, MAX48);
      @(negedge clk);
      evt = 32'h4; we = 1'b1; addr = A_CLR; wdata = 64'h10;
      @(negedge clk);
      we = 1'b0; evt = '0;
      rchk("R9 race keeps flag", A_STAT, 64'h10);
      rchk("R7 race counter", A_CNT + 12'd32, 64'd0);
      chk("R8 irq after race", {63'd0, irq}, 64'd1);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule